// File: doc/BRIEF.md
# One-Bit Handshake Buffer

This block is a single-bit buffer made from four small handshake components connected in a chain. A repeater starts the chain once it is activated. A two-step sequencer then runs two transfer elements, one after the other. A one-bit storage cell sits between the two transfer elements. Once activated, the buffer loops forever:

- It pulls one bit from the input channel into storage.
- It pushes the stored bit out on the output channel.
- Only after that does it ask for the next input.

Every channel, internal or external, uses four-phase return-to-zero signalling: request rises, acknowledge rises, request falls, acknowledge falls. Each component is a small clocked state machine, so every handshake wire is a register that advances on the common clock. The behaviour can therefore be synthesised and checked cycle by cycle.

The external data can be dual-rail, which is the default, or single-rail. In dual-rail form, `in_data[1]` is the true rail and `in_data[0]` is the false rail. An empty (spacer) code means no data yet, and the code with both rails high is illegal and raises a sticky flag.

A synchronous initialise input and an asynchronous active-low reset both return the block to idle. From idle it waits for a new activation.

Top module: `hs_buffer1`

## Requirements
- R1: After reset or initialise, `in_req` stays low until `act_req` is sampled high; `in_req` is then high after the third rising edge, counting the edge that first samples `act_req` high. `act_req` need not stay high.
- R2: `in_req` stays high until `in_ack` is seen with a non-spacer code; it is low after the first rising edge at which that holds. `in_req` is not raised again while `in_ack` is high.
- R3: Dual-rail input codes are `in_data` = 2'b10 for logic 1 and 2'b01 for logic 0. The code 2'b00 is a spacer: while it is present, `in_ack` high does not complete the input handshake and `in_req` stays high.
- R4: The code 2'b11 sampled with `in_req` and `in_ack` high sets `code_err`. The flag stays set until initialise or reset, and that transfer completes with the bit taken from the true rail (logic 1). Valid codes never set the flag.
- R5: `out_req` is high after the 13th rising edge, counting from the first edge that samples `in_ack` low. It then carries the captured bit, encoded as 2'b10 for 1 and 2'b01 for 0. `out_data` is 2'b00 whenever `out_req` is low.
- R6: While `out_ack` is low, `out_req` and `out_data` hold steady. `out_req` is low after the first rising edge that samples `out_ack` high.
- R7: `in_req` and `out_req` are never high together. With no further activation, the next `in_req` is high after the 9th rising edge, counting from the first edge that samples `out_ack` low. Transfers repeat indefinitely.
- R8: `init` high at a rising edge drives `in_req`, `out_req` and `code_err` low on that edge. The block then stays idle until a new activation (R1 timing).
- R9: `rst_n` low drops `in_req`, `out_req`, `out_data` and `code_err` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all handshake registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous initialise, active high |
| act_req | input | 1 | Activation request; never acknowledged |
| in_req | output | 1 | Request on the input data channel (buffer pulls) |
| in_ack | input | 1 | Acknowledge from the input data source |
| in_data | input | RAILS (2 by default) | Input bit, dual-rail by default |
| out_req | output | 1 | Request on the output data channel (buffer pushes) |
| out_ack | input | 1 | Acknowledge from the output data sink |
| out_data | output | RAILS (2 by default) | Output bit, spacer or zero when `out_req` is low |
| code_err | output | 1 | Sticky flag for an illegal dual-rail input code |

## Verification
Each result has a fixed due cycle, counted in rising edges from the stimulus that causes it:
- the first input request comes three edges after activation;
- the input request drops one edge after a valid acknowledge;
- the output request rises thirteen edges after the input acknowledge is withdrawn;
- the output request drops one edge after the output acknowledge;
- the next input request returns nine edges after the output acknowledge is withdrawn.

The bench drives each stimulus on a falling edge and counts falling edges before it samples. At every due point it checks the value one edge early and again on the due edge, so a result that comes too early or too late is caught. On every falling edge, a behavioural model holds the bit last offered to the buffer. The bench compares the output data against that model whenever a request is pending, and it checks that the two requests are never high together.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    F_IDLE, F_SRC_UP, F_SRC_DN, F_DST_UP, F_DST_DN, F_DONE
  } fetch_st_t;

  typedef enum logic [2:0] {
    S_IDLE, S_A_UP, S_A_DN, S_B_UP, S_B_DN, S_DONE
  } seq_st_t;

  function automatic logic [1:0] dr_encode(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  function automatic logic dr_is_data(input logic [1:0] c);
    return c != 2'b00;
  endfunction

  function automatic logic dr_is_bad(input logic [1:0] c);
    return c == 2'b11;
  endfunction

endpackage

// File: rtl/hs_loop.sv
module hs_loop (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic act,
  input  logic ack,
  output logic req
);
  logic run_q, run_d;
  logic req_q, req_d;

  always_comb begin
    run_d = run_q;
    req_d = req_q;
    if (!run_q) begin
      if (act) begin
        run_d = 1'b1;
        req_d = 1'b1;
      end
    end else if (req_q && ack) begin
      req_d = 1'b0;
    end else if (!req_q && !ack) begin
      req_d = 1'b1;
    end
    if (init) begin
      run_d = 1'b0;
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      run_q <= run_d;
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/hs_seq.sv
module hs_seq
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic p_req,
  output logic p_ack,
  output logic a_req,
  input  logic a_ack,
  output logic b_req,
  input  logic b_ack
);
  seq_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (p_req)  st_d = S_A_UP;
      S_A_UP: if (a_ack)  st_d = S_A_DN;
      S_A_DN: if (!a_ack) st_d = S_B_UP;
      S_B_UP: if (b_ack)  st_d = S_B_DN;
      S_B_DN: if (!b_ack) st_d = S_DONE;
      S_DONE: if (!p_req) st_d = S_IDLE;
      default:            st_d = S_IDLE;
    endcase
    if (init) st_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  assign a_req = (st_q == S_A_UP);
  assign b_req = (st_q == S_B_UP);
  assign p_ack = (st_q == S_DONE);
endmodule

// File: rtl/hs_fetch.sv
module hs_fetch
  import hs_pkg::*;
#(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         p_req,
  output logic         p_ack,
  output logic         src_req,
  input  logic         src_ack,
  input  logic         src_vld,
  input  logic [W-1:0] src_data,
  output logic         dst_req,
  input  logic         dst_ack,
  output logic [W-1:0] dst_data
);
  fetch_st_t    st_q, st_d;
  logic [W-1:0] data_q, data_d;
  logic         cap_en;

  assign cap_en = (st_q == F_SRC_UP) && src_ack && src_vld;

  always_comb begin
    st_d = st_q;
    case (st_q)
      F_IDLE:   if (p_req)    st_d = F_SRC_UP;
      F_SRC_UP: if (cap_en)   st_d = F_SRC_DN;
      F_SRC_DN: if (!src_ack) st_d = F_DST_UP;
      F_DST_UP: if (dst_ack)  st_d = F_DST_DN;
      F_DST_DN: if (!dst_ack) st_d = F_DONE;
      F_DONE:   if (!p_req)   st_d = F_IDLE;
      default:                st_d = F_IDLE;
    endcase
    if (init) st_d = F_IDLE;
  end

  always_comb begin
    data_d = data_q;
    if (cap_en) data_d = src_data;
    if (init)   data_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= F_IDLE;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
    end
  end

  assign src_req  = (st_q == F_SRC_UP);
  assign dst_req  = (st_q == F_DST_UP);
  assign p_ack    = (st_q == F_DONE);
  assign dst_data = data_q;
endmodule

// File: rtl/hs_var.sv
module hs_var #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  output logic         wr_ack,
  input  logic         rd_req,
  output logic         rd_ack,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] store_q, store_d;
  logic         wack_q, wack_d;
  logic         rack_q, rack_d;
  logic         st_en;

  assign st_en = wr_req && !wack_q;

  always_comb begin
    store_d = store_q;
    wack_d  = wack_q;
    rack_d  = rack_q;
    if (st_en) begin
      store_d = wr_data;
      wack_d  = 1'b1;
    end else if (!wr_req && wack_q) begin
      wack_d = 1'b0;
    end
    if (rd_req && !rack_q)      rack_d = 1'b1;
    else if (!rd_req && rack_q) rack_d = 1'b0;
    if (init) begin
      store_d = '0;
      wack_d  = 1'b0;
      rack_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      wack_q  <= 1'b0;
      rack_q  <= 1'b0;
    end else begin
      store_q <= store_d;
      wack_q  <= wack_d;
      rack_q  <= rack_d;
    end
  end

  assign wr_ack  = wack_q;
  assign rd_ack  = rack_q;
  assign rd_data = store_q;
endmodule

// File: rtl/hs_buffer1.sv
module hs_buffer1
  import hs_pkg::*;
#(
  parameter int unsigned DUAL_RAIL = 1,
  localparam int unsigned RAILS = (DUAL_RAIL != 0) ? 2 : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             act_req,
  output logic             in_req,
  input  logic             in_ack,
  input  logic [RAILS-1:0] in_data,
  output logic             out_req,
  input  logic             out_ack,
  output logic [RAILS-1:0] out_data,
  output logic             code_err
);
  localparam int unsigned BIT_W = 1;

  // control chain wires
  logic loop_req, loop_ack;
  logic s1_req, s1_ack;
  logic s2_req, s2_ack;
  // storage ports
  logic             wr_req, wr_ack, rd_req, rd_ack;
  logic [BIT_W-1:0] wr_data, rd_data;
  // channel-side data
  logic [BIT_W-1:0] in_bit, out_bit;
  logic             in_vld;
  logic             f2_dst_req;

  hs_loop u_loop (
    .clk(clk), .rst_n(rst_n), .init(init),
    .act(act_req), .ack(loop_ack), .req(loop_req)
  );

  hs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .init(init),
    .p_req(loop_req), .p_ack(loop_ack),
    .a_req(s1_req), .a_ack(s1_ack),
    .b_req(s2_req), .b_ack(s2_ack)
  );

  hs_fetch #(.W(BIT_W)) u_fetch_in (
    .clk(clk), .rst_n(rst_n), .init(init),
    .p_req(s1_req), .p_ack(s1_ack),
    .src_req(in_req), .src_ack(in_ack), .src_vld(in_vld), .src_data(in_bit),
    .dst_req(wr_req), .dst_ack(wr_ack), .dst_data(wr_data)
  );

  hs_var #(.W(BIT_W)) u_var (
    .clk(clk), .rst_n(rst_n), .init(init),
    .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  hs_fetch #(.W(BIT_W)) u_fetch_out (
    .clk(clk), .rst_n(rst_n), .init(init),
    .p_req(s2_req), .p_ack(s2_ack),
    .src_req(rd_req), .src_ack(rd_ack), .src_vld(1'b1), .src_data(rd_data),
    .dst_req(f2_dst_req), .dst_ack(out_ack), .dst_data(out_bit)
  );

  assign out_req = f2_dst_req;

  generate
    if (DUAL_RAIL != 0) begin : g_dual
      logic err_q, err_d, err_set;

      assign in_bit   = in_data[1];
      assign in_vld   = dr_is_data(in_data);
      assign out_data = f2_dst_req ? dr_encode(out_bit[0]) : 2'b00;
      assign err_set  = in_req && in_ack && dr_is_bad(in_data);

      always_comb begin
        err_d = err_q | err_set;
        if (init) err_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
      end

      assign code_err = err_q;
    end else begin : g_single
      assign in_bit   = in_data[0];
      assign in_vld   = 1'b1;
      assign out_data = f2_dst_req ? out_bit : 1'b0;
      assign code_err = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/hs_buffer1_chk.sv
module hs_buffer1_chk #(
  parameter int unsigned RAILS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             in_req,
  input logic             in_ack,
  input logic             out_req,
  input logic             out_ack,
  input logic [RAILS-1:0] out_data,
  input logic             code_err
);
  // R2
  in_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_req && !in_ack && !init) |=> in_req);

  // R2
  in_rz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_req && in_ack) |=> !in_req);

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !out_ack && !init) |=> (out_req && $stable(out_data)));

  // R7
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_req && out_req));

  // R8
  init_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!in_req && !out_req && !code_err));

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_err && !init) |=> code_err);

  generate
    if (RAILS == 2) begin : g_dr
      // R5
      out_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |-> (out_data == 2'b01 || out_data == 2'b10));
      // R5
      out_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_req |-> (out_data == 2'b00));
    end
  endgenerate
endmodule

bind hs_buffer1 hs_buffer1_chk #(.RAILS(RAILS)) u_hs_buffer1_chk (
  .clk(clk), .rst_n(rst_n), .init(init),
  .in_req(in_req), .in_ack(in_ack),
  .out_req(out_req), .out_ack(out_ack), .out_data(out_data),
  .code_err(code_err)
);

// File: tb/test_hs_buffer1.sv
module test_hs_buffer1;
  logic       clk = 1'b0;
  logic       rst_n, init, act_req, in_ack, out_ack;
  logic [1:0] in_data, out_data;
  logic       in_req, out_req, code_err;

  int checks = 0;
  int errors = 0;
  logic model_bit = 1'b0;
  bit   mon_on = 1'b0;

  always #5 clk = ~clk;

  hs_buffer1 i_hs_buffer1 (
    .clk(clk), .rst_n(rst_n), .init(init), .act_req(act_req),
    .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data),
    .code_err(code_err)
  );

  task automatic chk(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk("R7", "requests exclusive", int'(in_req && out_req), 0);
      if (out_req) chk("R5", "output matches model", int'(out_data), model_bit ? 2 : 1);
      else         chk("R5", "spacer while idle", int'(out_data), 0);
    end
  end

  task automatic activate();
    act_req = 1'b1;
    @(negedge clk);
    act_req = 1'b0;
    @(negedge clk);
    chk("R1", "in_req before third edge", int'(in_req), 0);
    @(negedge clk);
    chk("R1", "in_req on third edge", int'(in_req), 1);
  endtask

  task automatic transfer(input logic [1:0] code, input int spacer, input logic exp_bit);
    chk("R2", "in_req pending", int'(in_req), 1);
    if (spacer > 0) begin
      in_data = 2'b00;
      in_ack  = 1'b1;
      repeat (spacer) @(negedge clk);
      chk("R3", "spacer does not complete", int'(in_req), 1);
    end
    model_bit = exp_bit;
    in_data = code;
    in_ack  = 1'b1;
    @(negedge clk);
    chk("R2", "in_req drops after ack", int'(in_req), 0);
    in_ack  = 1'b0;
    in_data = 2'b00;
    repeat (12) @(negedge clk);
    chk("R5", "out_req not early", int'(out_req), 0);
    @(negedge clk);
    chk("R5", "out_req on 13th edge", int'(out_req), 1);
    chk("R5", "out_data code", int'(out_data), exp_bit ? 2 : 1);
    repeat (3) @(negedge clk);
    chk("R6", "out_req held without ack", int'(out_req), 1);
    out_ack = 1'b1;
    @(negedge clk);
    chk("R6", "out_req drops after ack", int'(out_req), 0);
    chk("R5", "out_data spacer", int'(out_data), 0);
    out_ack = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7", "next in_req not early", int'(in_req), 0);
    @(negedge clk);
    chk("R7", "next in_req on 9th edge", int'(in_req), 1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; init = 1'b0; act_req = 1'b0;
    in_ack = 1'b0; out_ack = 1'b0; in_data = 2'b00;
    repeat (3) @(negedge clk);
    chk("R9", "reset in_req", int'(in_req), 0);
    chk("R9", "reset out_req", int'(out_req), 0);
    chk("R9", "reset out_data", int'(out_data), 0);
    chk("R9", "reset code_err", int'(code_err), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "idle without activation", int'(in_req), 0);

    activate();
    transfer(2'b10, 0, 1'b1);
    transfer(2'b01, 0, 1'b0);
    transfer(2'b01, 0, 1'b0);
    transfer(2'b10, 3, 1'b1);
    chk("R3", "valid codes leave flag clear", int'(code_err), 0);
    transfer(2'b11, 0, 1'b1);
    chk("R4", "illegal code flagged", int'(code_err), 1);
    transfer(2'b01, 2, 1'b0);
    chk("R4", "flag sticky", int'(code_err), 1);

    // synchronous initialise with a request pending
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    chk("R8", "init drops in_req", int'(in_req), 0);
    chk("R8", "init drops out_req", int'(out_req), 0);
    chk("R8", "init clears flag", int'(code_err), 0);
    repeat (6) @(negedge clk);
    chk("R8", "idle after init", int'(in_req), 0);
    activate();
    transfer(2'b10, 0, 1'b1);

    // asynchronous reset with a request pending
    rst_n = 1'b0;
    #1;
    chk("R9", "async reset in_req", int'(in_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "idle after reset", int'(in_req), 0);
    activate();
    transfer(2'b01, 0, 1'b0);

    finish_run();
  end
endmodule